// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the integer execution unit of a 32-bit processor pipeline. It takes two operands that have already been read, with the second one already through the barrel shifter, and the carry the shifter produced. It also takes a four-bit opcode, the set-flags bit, the current condition flags and the destination register index. One cycle later it presents the result, a register write strobe, a branch-to-result strobe when the destination is the program counter, the next condition flags, and the cycle cost of the instruction.

The register file, condition evaluation, the shifter and the status-register restore are outside the block. When the result is sent to the program counter and the set-flags bit is on, the block only raises a restore request. Flags that an instruction does not change are copied from the flag input, so the block holds no flag state of its own.

Top module: `dp_alu`

## Requirements
- R1: Logical opcodes give these results: 0 a&b, 1 a^b, 12 a|b, 13 b, 14 a&~b, 15 ~b. Test opcode 8 computes a&b and test opcode 9 computes a^b.
- R2: Arithmetic opcodes give these results modulo 2^32: 2 a-b, 3 b-a, 4 a+b, 5 a+b+C, 6 a-b-(1-C), 7 b-a-(1-C). Compare opcode 10 computes a-b and compare opcode 11 computes a+b. C is bit 1 of flags_i.
- R3: Each output appears in the first rising edge after valid_i is sampled high. With valid_i low, valid_o, wr_en_o, jump_o and restore_o are 0. Reset clears every output to 0.
- R4: For a subtraction x-y, carry is 1 when x>=y as unsigned values. Opcodes 3 and 7 use x=b, y=a. All other subtractions use x=a, y=b. For an addition, carry is the carry out of bit 31.
- R5: For an addition, V is 1 when both operands have the same sign and the sign of the result differs from them. For a subtraction x-y, V is 1 when the signs of x and y differ and the sign of the result differs from x.
- R6: Opcodes 5, 6 and 7 are computed in two steps: first x op y, then that partial result op k. For opcode 5, k=C. For opcodes 6 and 7, k=1-C. The C and V outputs are the OR of the R4 and R5 flags of the two steps. As a result, opcodes 6 and 7 always give C=1 when C was 1.
- R7: When flags are updated by a logical opcode (0, 1, 8, 9, 12 to 15), N is bit 31 of the result and Z is 1 when the result is zero. C is taken from shift_carry_i, and V keeps its flags_i value. flags_o is packed as {N,Z,C,V} in bits 3..0, and flags_i uses the same packing.
- R8: A non-test opcode with set_flags_i low returns flags_i unchanged.
- R9: Opcodes 8 to 11 always update the flags. They never assert wr_en_o, jump_o or restore_o, whatever the destination index.
- R10: When a non-test opcode targets index 15, jump_o is asserted instead of wr_en_o. restore_o is also asserted when set_flags_i is high. Any other destination asserts wr_en_o.
- R11: The cost fields are set as follows. seq_cyc_o is 2 when jump_o is asserted and 1 otherwise. nseq_cyc_o equals jump_o. int_cyc_o equals the reg_shift_i that was sampled with the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| opcode_i | input | 4 | Operation code, 0 to 15 |
| set_flags_i | input | 1 | Update the flags |
| reg_shift_i | input | 1 | Shift amount came from a register |
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Shifted second operand |
| shift_carry_i | input | 1 | Shifter carry out |
| flags_i | input | 4 | Current {N,Z,C,V} |
| dst_i | input | 4 | Destination register index |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Write result to the register file |
| jump_o | output | 1 | Branch to result |
| restore_o | output | 1 | Restore-status request |
| flags_o | output | 4 | Next {N,Z,C,V} |
| seq_cyc_o | output | 2 | Sequential cycles |
| int_cyc_o | output | 1 | Internal cycles |
| nseq_cyc_o | output | 1 | Non-sequential cycles |

## Verification
The assertions assume that opcode_i, set_flags_i, flags_i and dst_i hold defined values in every cycle where valid_i is high. They also assume that flags_i is the architectural flag state as it stands at that moment, because the held-flag properties compare flags_o with the sampled flags_i. The stimulus always drives valid_i to a known level and fills every field of each instruction before raising it. It sweeps every opcode against operand pairs taken from 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, crossed with both carry-in values and both set-flags values, and then runs random traffic that includes idle cycles.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  function automatic logic op_is_test(alu_op_e op);
    return op inside {OP_TST, OP_TEQ, OP_CMP, OP_CMN};
  endfunction

  function automatic logic op_is_arith(alu_op_e op);
    return op inside {OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC, OP_CMP, OP_CMN};
  endfunction
endpackage

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND, OP_TST: res_o = a_i & b_i;
      OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
      OP_ORR:         res_o = a_i | b_i;
      OP_MOV:         res_o = b_i;
      OP_BIC:         res_o = a_i & ~b_i;
      OP_MVN:         res_o = ~b_i;
      default:        res_o = '0;
    endcase
  end
endmodule

// File: rtl/dp_alu_arith.sv
module dp_alu_arith
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] res_o,
  output logic             c_o,
  output logic             v_o
);
  localparam int MSB = WIDTH - 1;

  logic             swap, subtract, chain;
  logic [WIDTH-1:0] x, y, k, tmp;
  logic [WIDTH:0]   sum1, sum2;
  logic             c1, c2, v1, v2;

  always_comb begin
    swap     = op_i inside {OP_RSB, OP_RSC};
    subtract = op_i inside {OP_SUB, OP_RSB, OP_SBC, OP_RSC, OP_CMP};
    chain    = op_i inside {OP_ADC, OP_SBC, OP_RSC};
    x = swap ? b_i : a_i;
    y = swap ? a_i : b_i;
    k = '0;
    // second step adds carry, or subtracts the inverted carry
    k[0] = chain & (subtract ? ~cin_i : cin_i);
    if (subtract) begin
      sum1 = {1'b0, x} - {1'b0, y};
      tmp  = sum1[MSB:0];
      c1   = ~sum1[WIDTH];
      v1   = (x[MSB] ^ y[MSB]) & (x[MSB] ^ tmp[MSB]);
      sum2 = {1'b0, tmp} - {1'b0, k};
      c2   = ~sum2[WIDTH];
      v2   = (tmp[MSB] ^ k[MSB]) & (tmp[MSB] ^ sum2[MSB]);
    end else begin
      sum1 = {1'b0, x} + {1'b0, y};
      tmp  = sum1[MSB:0];
      c1   = sum1[WIDTH];
      v1   = ~(x[MSB] ^ y[MSB]) & (x[MSB] ^ tmp[MSB]);
      sum2 = {1'b0, tmp} + {1'b0, k};
      c2   = sum2[WIDTH];
      v2   = ~(tmp[MSB] ^ k[MSB]) & (tmp[MSB] ^ sum2[MSB]);
    end
    res_o = sum2[MSB:0];
    c_o   = c1 | (chain & c2);
    v_o   = v1 | (chain & v2);
  end
endmodule

// File: rtl/dp_alu_wb_ctrl.sv
module dp_alu_wb_ctrl #(
  parameter int IDX_W  = 4,
  parameter int PC_IDX = 15
) (
  input  logic             valid_i,
  input  logic             is_test_i,
  input  logic             set_flags_i,
  input  logic             reg_shift_i,
  input  logic [IDX_W-1:0] dst_i,
  output logic             wr_en_o,
  output logic             jump_o,
  output logic             restore_o,
  output logic [1:0]       seq_o,
  output logic             int_o,
  output logic             nseq_o
);
  logic to_pc, writes;

  always_comb begin
    to_pc     = (dst_i == IDX_W'(PC_IDX));
    writes    = valid_i & ~is_test_i;
    wr_en_o   = writes & ~to_pc;
    jump_o    = writes & to_pc;
    restore_o = jump_o & set_flags_i;
    seq_o     = jump_o ? 2'd2 : 2'd1;
    int_o     = reg_shift_i;
    nseq_o    = jump_o;
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int IDX_W  = 4,
  parameter int PC_IDX = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [3:0]       opcode_i,
  input  logic             set_flags_i,
  input  logic             reg_shift_i,
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  input  logic             shift_carry_i,
  input  logic [3:0]       flags_i,
  input  logic [IDX_W-1:0] dst_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] result_o,
  output logic             wr_en_o,
  output logic             jump_o,
  output logic             restore_o,
  output logic [3:0]       flags_o,
  output logic [1:0]       seq_cyc_o,
  output logic             int_cyc_o,
  output logic             nseq_cyc_o
);
  alu_op_e          op;
  flags_t           f_in, f_nxt;
  logic [WIDTH-1:0] logic_res, arith_res, res;
  logic             arith_c, arith_v, is_test, is_arith;
  logic             wr_d, jump_d, restore_d, int_d, nseq_d;
  logic [1:0]       seq_d;

  assign op   = alu_op_e'(opcode_i);
  assign f_in = flags_t'(flags_i);

  dp_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .op_i (op), .a_i(op_a_i), .b_i(op_b_i), .res_o(logic_res)
  );

  dp_alu_arith #(.WIDTH(WIDTH)) u_arith (
    .op_i (op), .a_i(op_a_i), .b_i(op_b_i), .cin_i(f_in.c),
    .res_o(arith_res), .c_o(arith_c), .v_o(arith_v)
  );

  dp_alu_wb_ctrl #(.IDX_W(IDX_W), .PC_IDX(PC_IDX)) u_ctrl (
    .valid_i    (valid_i),
    .is_test_i  (is_test),
    .set_flags_i(set_flags_i),
    .reg_shift_i(reg_shift_i),
    .dst_i      (dst_i),
    .wr_en_o    (wr_d),
    .jump_o     (jump_d),
    .restore_o  (restore_d),
    .seq_o      (seq_d),
    .int_o      (int_d),
    .nseq_o     (nseq_d)
  );

  always_comb begin
    is_test  = op_is_test(op);
    is_arith = op_is_arith(op);
    res      = is_arith ? arith_res : logic_res;
    f_nxt    = f_in;
    if (is_test || set_flags_i) begin
      f_nxt.n = res[WIDTH-1];
      f_nxt.z = (res == '0);
      if (is_arith) begin
        f_nxt.c = arith_c;
        f_nxt.v = arith_v;
      end else begin
        f_nxt.c = shift_carry_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      result_o   <= '0;
      wr_en_o    <= 1'b0;
      jump_o     <= 1'b0;
      restore_o  <= 1'b0;
      flags_o    <= '0;
      seq_cyc_o  <= '0;
      int_cyc_o  <= 1'b0;
      nseq_cyc_o <= 1'b0;
    end else begin
      valid_o   <= valid_i;
      wr_en_o   <= wr_d;
      jump_o    <= jump_d;
      restore_o <= restore_d;
      if (valid_i) begin
        result_o   <= res;
        flags_o    <= f_nxt;
        seq_cyc_o  <= seq_d;
        int_cyc_o  <= int_d;
        nseq_cyc_o <= nseq_d;
      end
    end
  end
endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic [3:0] opcode_i,
  input logic       set_flags_i,
  input logic [3:0] flags_i,
  input logic       valid_o,
  input logic       wr_en_o,
  input logic       jump_o,
  input logic       restore_o,
  input logic [3:0] flags_o,
  input logic [1:0] seq_cyc_o,
  input logic       nseq_cyc_o
);
  logic test_op, arith_op;
  assign test_op  = (opcode_i[3:2] == 2'b10);
  assign arith_op = (opcode_i >= 4'd2 && opcode_i <= 4'd7) || opcode_i == 4'd10 || opcode_i == 4'd11;

  AST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_i |=> valid_o); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) !valid_o |-> !wr_en_o && !jump_o && !restore_o); // R3
  AST_TEST_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni) (valid_i && test_op) |=> !wr_en_o && !jump_o && !restore_o); // R9
  AST_HOLD_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni) (valid_i && !test_op && !set_flags_i) |=> flags_o == $past(flags_i)); // R8
  AST_LOGIC_V_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) (valid_i && !arith_op) |=> flags_o[0] == $past(flags_i[0])); // R7
  AST_WR_JUMP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0({wr_en_o, jump_o})); // R10
  AST_RESTORE_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni) restore_o |-> jump_o); // R10
  AST_COST: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_o |-> (seq_cyc_o == (jump_o ? 2'd2 : 2'd1)) && (nseq_cyc_o == jump_o)); // R11
endmodule

bind dp_alu dp_alu_chk u_chk (.*);

// File: tb/dp_alu_tb.sv
module dp_alu_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  opcode_i = '0;
  logic        set_flags_i = 1'b0, reg_shift_i = 1'b0, shift_carry_i = 1'b0;
  logic [31:0] op_a_i = '0, op_b_i = '0;
  logic [3:0]  flags_i = '0, dst_i = '0;
  logic        valid_o, wr_en_o, jump_o, restore_o, int_cyc_o, nseq_cyc_o;
  logic [31:0] result_o;
  logic [3:0]  flags_o;
  logic [1:0]  seq_cyc_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  dp_alu dut_i (.*);

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit vadd(logic [31:0] x, y, r);
    return (x[31] == y[31]) && (r[31] != x[31]);
  endfunction
  function automatic bit vsub(logic [31:0] x, y, r);
    return (x[31] != y[31]) && (r[31] != x[31]);
  endfunction

  task automatic run_one(int op, bit s, bit rs, logic [31:0] a, b, bit sc, logic [3:0] fl, logic [3:0] dst);
    logic [31:0] r, tmp, x, y, k;
    longint unsigned t;
    bit ac = 0, av = 0, cin, is_t, is_a, we, jp, rq;
    logic [3:0] f;
    string tag_r, tag_f, tag_w;
    cin  = fl[1];
    is_t = (op >= 8 && op <= 11);
    is_a = (op >= 2 && op <= 7) || op == 10 || op == 11;
    x = (op == 3 || op == 7) ? b : a;
    y = (op == 3 || op == 7) ? a : b;
    case (op)
      0, 8: r = a & b;
      1, 9: r = a ^ b;
      12:   r = a | b;
      13:   r = b;
      14:   r = a & ~b;
      15:   r = ~b;
      2, 3, 10: begin r = x - y; ac = (x >= y); av = vsub(x, y, r); end
      4, 11: begin
        t = longint'(a) + longint'(b); r = t[31:0];
        ac = t > 64'hFFFFFFFF; av = vadd(a, b, r);
      end
      5: begin // R6 add with carry
        t = longint'(a) + longint'(b); tmp = t[31:0]; k = {31'd0, cin};
        ac = t > 64'hFFFFFFFF;
        t = longint'(tmp) + longint'(k); r = t[31:0];
        ac = ac || (t > 64'hFFFFFFFF);
        av = vadd(a, b, tmp) || vadd(tmp, k, r);
      end
      default: begin // R6 subtract with borrow (6, 7)
        tmp = x - y; k = {31'd0, !cin}; r = tmp - k;
        ac = (x >= y) || (tmp >= k);
        av = vsub(x, y, tmp) || vsub(tmp, k, r);
      end
    endcase
    f = fl;
    if (is_t || s) begin
      f[3] = r[31];
      f[2] = (r == 0);
      f[1] = is_a ? ac : sc;
      if (is_a) f[0] = av;
    end
    we = !is_t && dst != 4'd15;
    jp = !is_t && dst == 4'd15;
    rq = jp && s;
    tag_r = is_a ? "R2" : "R1";
    tag_f = is_t ? "R9" : (op == 5 || op == 6 || op == 7) ? "R6" : is_a ? "R4 R5" : s ? "R7" : "R8";
    if (!is_t && !s) tag_f = "R8";
    tag_w = is_t ? "R9" : "R10";

    @(negedge clk_i);
    valid_i = 1'b1; opcode_i = 4'(op); set_flags_i = s; reg_shift_i = rs;
    op_a_i = a; op_b_i = b; shift_carry_i = sc; flags_i = fl; dst_i = dst;
    @(posedge clk_i); #1;
    chk(valid_o == 1'b1, "R3", "valid", 32'(valid_o), 32'd1);
    chk(result_o == r, tag_r, $sformatf("result op%0d", op), result_o, r);
    chk(flags_o == f, tag_f, $sformatf("flags op%0d", op), 32'(flags_o), 32'(f));
    chk(wr_en_o == we, tag_w, "wr_en", 32'(wr_en_o), 32'(we));
    chk(jump_o == jp, tag_w, "jump", 32'(jump_o), 32'(jp));
    chk(restore_o == rq, tag_w, "restore", 32'(restore_o), 32'(rq));
    chk(seq_cyc_o == (jp ? 2'd2 : 2'd1), "R11", "seq", 32'(seq_cyc_o), jp ? 32'd2 : 32'd1);
    chk(nseq_cyc_o == jp && int_cyc_o == rs, "R11", "nseq/int", {30'd0, nseq_cyc_o, int_cyc_o}, {30'd0, jp, rs});
  endtask

  task automatic idle_check();
    @(negedge clk_i);
    valid_i = 1'b0;
    opcode_i = 4'd13; dst_i = 4'd15; set_flags_i = 1'b1;
    @(posedge clk_i); #1;
    chk(!valid_o && !wr_en_o && !jump_o && !restore_o, "R3", "idle strobes",
        {28'd0, valid_o, wr_en_o, jump_o, restore_o}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] bv [5];
    int cnt = 0;
    bv = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF};
    repeat (3) @(posedge clk_i);
    #1;
    // R3 reset state
    chk(!valid_o && !wr_en_o && !jump_o && !restore_o && result_o == 0 && flags_o == 0,
        "R3", "reset state", result_o, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int op = 0; op < 16; op++)
      for (int ia = 0; ia < 5; ia++)
        for (int ib = 0; ib < 5; ib++)
          for (int k = 0; k < 4; k++) begin
            cnt++;
            run_one(op, k[0], cnt[1], bv[ia], bv[ib], cnt[2],
                    {cnt[4], cnt[5], k[1], cnt[3]},
                    (cnt % 4 == 0) ? 4'd15 : 4'(cnt));
            if (cnt % 97 == 0) idle_check();
          end
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      run_one(int'(rv[3:0]), rv[4], rv[5], $urandom, $urandom, rv[6], rv[10:7], rv[14:11]);
      if (rv[20:17] == 0) idle_check();
    end
    idle_check();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule